// File: doc/BRIEF.md
# Dual-Clock FIFO With Retransmit

This block is a first-in first-out buffer of 512 words of 36 bits. A producer on the write clock pushes words into it, and a consumer on the independent read clock pops them out. Both data interfaces use a valid/ready handshake. On the write side a word moves on a `clk_a` edge where `wr_valid` and `wr_ready` are both high. When `wr_ready` is low, the producer must hold its word and wait. On the read side a word leaves on a `clk_b` edge where `rd_valid` and `rd_ready` are both high, and `rd_data` shows the head word whenever `rd_valid` is high. The consumer may drop `rd_ready` at any time. The FIFO then keeps the head word in place. Two status flags warn ahead of time: `rd_almost_empty` in the read domain and `wr_almost_full` in the write domain.

Retransmit lets the consumer replay data it has already read. A shadow read pointer marks the replay point. While `rt_mode` is high the shadow stays fixed and reads advance only the live read pointer. The write side counts free space from the shadow, so replayable words cannot be overwritten. Pulsing `rt_reload` while in retransmit mode moves the read pointer back to the shadow. Dropping `rt_mode` releases the retained words. From that edge the shadow walks forward one entry per read clock until it reaches the read pointer. Pointers cross between the clocks in Gray code through two flip-flop stages.

Top module: `fifo_rt`

## Requirements
- R1: While `rst_n` is low and just after it is released, `rd_valid` is 0, `wr_ready` is 1, `rd_almost_empty` is 1 and `wr_almost_full` is 0.
- R2: Words leave in the order they were accepted, with their data unchanged. A word moves only on an edge where valid and ready are both high on that port.
- R3: Counted from the shadow pointer, `wr_ready` is low exactly when 512 words are held. A write offered while `wr_ready` is low is dropped and leaves the contents unchanged.
- R4: A read requested while `rd_valid` is low is ignored and does not move the read pointer.
- R5: `rd_almost_empty` is high when the unread word count seen by the read side is at most AE_OFS (default 8), and low otherwise.
- R6: `wr_almost_full` is high when the number of words held from the shadow pointer is at least 512 minus AF_OFS (default 504), and low otherwise.
- R7: While `rt_mode` is high, reads advance the read pointer but the shadow pointer stays put, so no space is freed for the write side. While `rt_mode` is low, the shadow moves forward one entry per `clk_b` edge until it equals the read pointer.
- R8: On a `clk_b` edge where `rt_mode` and `rt_reload` are both high, the read pointer takes the shadow's value and no word is popped. Right after that edge, `rd_valid` and `rd_data` show the replayed word with no synchronization delay.
- R9: After a reload, `rd_almost_empty` matches the new fill level within two `clk_b` edges of the reload edge.
- R10: Space released by leaving retransmit mode reaches `wr_ready` only after at least two `clk_a` edges.
- R11: Each pointer that crosses between the clocks changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | FIFO can accept a word (input-ready) |
| wr_data | input | DATA_W | Word to be written |
| wr_almost_full | output | 1 | Fill from the shadow pointer is at least 512 minus AF_OFS |
| rd_valid | output | 1 | `rd_data` holds an unread word (output-ready) |
| rd_ready | input | 1 | Consumer takes the word on `rd_data` |
| rd_data | output | DATA_W | Head word |
| rd_almost_empty | output | 1 | Unread fill is at most AE_OFS |
| rt_mode | input | 1 | Retransmit mode; holds the shadow pointer |
| rt_reload | input | 1 | In retransmit mode, rewinds the read pointer to the shadow |

## Verification
The hardest case to reach is a full buffer whose free space depends only on the shadow. The write side must stay blocked while the consumer reads well past the replay point, and must unblock only after retransmit ends. The stimulus fills all 512 entries and lets the shadow settle. It then enters retransmit mode, reads 40 words, and confirms that `wr_ready` and `wr_almost_full` do not move. Next it reloads, checks that the replay point is on the output on the very next cycle, reads again and leaves retransmit mode. A separate run shrinks the fill below the almost-empty threshold and then reloads, to watch that flag recover.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef enum logic {
    SHD_TRACK = 1'b0,
    SHD_HOLD  = 1'b1
  } shadow_mode_e;
endpackage

// File: rtl/fifo_rt_sync.sv
module fifo_rt_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stg1, stg2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= '0;
      stg2 <= '0;
    end else begin
      stg1 <= gray_in;
      stg2 <= stg1;
    end
  end

  // Gray to binary: each bit is the parity of itself and all higher bits.
  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_out[i] = ^stg2[W-1:i];
  end
endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int DW = 36,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int NWORDS = 1 << AW;
  logic [DW-1:0] store [NWORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/fifo_rt_wctl.sv
module fifo_rt_wctl #(
  parameter int AW     = 9,
  parameter int AF_OFS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW:0]   rd_bin,
  output logic          wr_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW:0]   wr_gray,
  output logic          almost_full
);
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] AF_LVL  = DEPTH_V - (AW+1)'(AF_OFS);

  logic [AW:0] wptr, wptr_nxt, fill, fill_nxt;

  assign fill     = wptr - rd_bin;
  assign wr_ready = (fill != DEPTH_V);
  assign wr_en    = wr_valid & wr_ready;
  assign wptr_nxt = wptr + {{AW{1'b0}}, wr_en};
  assign fill_nxt = wptr_nxt - rd_bin;
  assign wr_addr  = wptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr        <= '0;
      wr_gray     <= '0;
      almost_full <= 1'b0;
    end else begin
      wptr        <= wptr_nxt;
      wr_gray     <= wptr_nxt ^ (wptr_nxt >> 1);
      almost_full <= (fill_nxt >= AF_LVL);
    end
  end
endmodule

// File: rtl/fifo_rt_rctl.sv
module fifo_rt_rctl
  import fifo_rt_pkg::*;
#(
  parameter int AW     = 9,
  parameter int AE_OFS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_ready,
  input  logic          rt_mode,
  input  logic          rt_reload,
  input  logic [AW:0]   wr_bin,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0]   shadow_gray,
  output logic [AW:0]   shadow_ptr,
  output logic          almost_empty
);
  localparam logic [AW:0] AE_LVL = (AW+1)'(AE_OFS);

  shadow_mode_e smode;
  logic [AW:0]  rptr, rptr_nxt, shadow, shadow_nxt;
  logic         reload, pop;

  assign smode    = rt_mode ? SHD_HOLD : SHD_TRACK;
  assign reload   = rt_mode & rt_reload;
  assign rd_valid = (rptr != wr_bin);
  assign pop      = rd_ready & rd_valid & ~reload;

  always_comb begin
    if (reload) rptr_nxt = shadow;
    else        rptr_nxt = rptr + {{AW{1'b0}}, pop};
  end

  // Outside retransmit the shadow trails the read pointer one step per edge,
  // so its Gray image never changes by more than one bit.
  always_comb begin
    shadow_nxt = shadow;
    if (smode == SHD_TRACK && shadow != rptr) shadow_nxt = shadow + 1'b1;
  end

  assign rd_addr    = rptr[AW-1:0];
  assign shadow_ptr = shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr         <= '0;
      shadow       <= '0;
      shadow_gray  <= '0;
      almost_empty <= 1'b1;
    end else begin
      rptr         <= rptr_nxt;
      shadow       <= shadow_nxt;
      shadow_gray  <= shadow_nxt ^ (shadow_nxt >> 1);
      almost_empty <= ((wr_bin - rptr_nxt) <= AE_LVL);
    end
  end
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 9,
  parameter int AE_OFS = 8,
  parameter int AF_OFS = 8
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_almost_full,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_almost_empty,
  input  logic              rt_mode,
  input  logic              rt_reload
);
  localparam int PW = ADDR_W + 1;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PW-1:0]     wr_gray, wr_bin_b;
  logic [PW-1:0]     shadow_gray, shadow_ptr, rd_bin_a;

  fifo_rt_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .clk(clk_a), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  fifo_rt_wctl #(.AW(ADDR_W), .AF_OFS(AF_OFS)) u_wctl (
    .clk(clk_a), .rst_n(rst_n), .wr_valid(wr_valid), .rd_bin(rd_bin_a),
    .wr_ready(wr_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_gray(wr_gray), .almost_full(wr_almost_full)
  );

  fifo_rt_rctl #(.AW(ADDR_W), .AE_OFS(AE_OFS)) u_rctl (
    .clk(clk_b), .rst_n(rst_n), .rd_ready(rd_ready), .rt_mode(rt_mode),
    .rt_reload(rt_reload), .wr_bin(wr_bin_b), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .shadow_gray(shadow_gray), .shadow_ptr(shadow_ptr),
    .almost_empty(rd_almost_empty)
  );

  fifo_rt_sync #(.W(PW)) u_w2r (
    .clk(clk_b), .rst_n(rst_n), .gray_in(wr_gray), .bin_out(wr_bin_b)
  );

  fifo_rt_sync #(.W(PW)) u_r2w (
    .clk(clk_a), .rst_n(rst_n), .gray_in(shadow_gray), .bin_out(rd_bin_a)
  );
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int AW = 9
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst_n,
  input logic          wr_ready,
  input logic          wr_almost_full,
  input logic          rd_valid,
  input logic          rd_almost_empty,
  input logic          rt_mode,
  input logic          rt_reload,
  input logic [AW-1:0] rd_addr,
  input logic [AW:0]   wr_gray,
  input logic [AW:0]   shadow_gray,
  input logic [AW:0]   shadow_ptr
);
  logic [AW-1:0] shadow_lo;
  assign shadow_lo = shadow_ptr[AW-1:0];

  a_r3_no_write_when_full: assert property (@(posedge clk_a) disable iff (!rst_n)
    !wr_ready |=> $stable(wr_gray));

  a_r4_no_read_when_empty: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!rd_valid && !rt_reload) |=> $stable(rd_addr));

  a_r5_empty_is_almost_empty: assert property (@(posedge clk_b) disable iff (!rst_n)
    !rd_valid |-> rd_almost_empty);

  a_r6_full_is_almost_full: assert property (@(posedge clk_a) disable iff (!rst_n)
    !wr_ready |-> wr_almost_full);

  a_r7_shadow_frozen: assert property (@(posedge clk_b) disable iff (!rst_n)
    rt_mode |=> $stable(shadow_gray));

  a_r8_reload_target: assert property (@(posedge clk_b) disable iff (!rst_n)
    (rt_mode && rt_reload) |=> (rd_addr == $past(shadow_lo)));

  a_r11_wr_gray_step: assert property (@(posedge clk_a) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  a_r11_shadow_gray_step: assert property (@(posedge clk_b) disable iff (!rst_n)
    $countones(shadow_gray ^ $past(shadow_gray)) <= 1);
endmodule

bind fifo_rt fifo_rt_chk #(.AW(ADDR_W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
  .wr_ready(wr_ready), .wr_almost_full(wr_almost_full),
  .rd_valid(rd_valid), .rd_almost_empty(rd_almost_empty),
  .rt_mode(rt_mode), .rt_reload(rt_reload), .rd_addr(rd_addr),
  .wr_gray(wr_gray), .shadow_gray(shadow_gray), .shadow_ptr(shadow_ptr)
);

// File: tb/tb_fifo_rt.sv
`timescale 1ns/1ps
module tb_fifo_rt;
  localparam int DW = 36;
  localparam int DEPTH = 512;
  localparam int AE = 8;
  localparam int AF = 8;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0, rt_mode = 1'b0, rt_reload = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, wr_almost_full, rd_valid, rd_almost_empty;
  logic [DW-1:0] rd_data;

  always #10 clk_a = ~clk_a;   // 50 MHz
  always #13 clk_b = ~clk_b;

  fifo_rt dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_almost_full(wr_almost_full), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_almost_empty(rd_almost_empty),
    .rt_mode(rt_mode), .rt_reload(rt_reload)
  );

  // Reference model: absolute word counters.
  int  wcount = 0, rcount = 0, rt_entry = 0;
  bit  in_rt = 1'b0, mon_on = 1'b0, done = 1'b0;
  int  n_chk = 0, n_fail = 0;

  function automatic logic [DW-1:0] gen(int i);
    logic [17:0] k;
    k = i[17:0];
    return {k ^ 18'h2A5C3, k};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int freed();
    return in_rt ? rt_entry : rcount;
  endfunction

  // Per-clock comparison against the model (R2, R8, R3).
  always @(negedge clk_b) begin
    if (mon_on && rd_valid) begin
      chk(rcount < wcount, "R2", "valid without data", rcount, wcount);
      chk(rd_data == gen(rcount), "R2", "head word", rd_data, gen(rcount));
    end
  end

  always @(negedge clk_a) begin
    if (mon_on && wr_ready)
      chk((wcount - freed()) < DEPTH, "R3", "ready while full", wcount - freed(), DEPTH - 1);
  end

  task automatic wr_words(input int n, input int gap);
    int got = 0;
    int it = 0;
    bit acc;
    while (got < n) begin
      @(negedge clk_a);
      wr_valid = !(gap > 0 && (it % gap) == gap - 1);
      wr_data  = gen(wcount);
      acc      = wr_valid && wr_ready;
      @(posedge clk_a);
      if (acc) begin wcount++; got++; end
      it++;
    end
    @(negedge clk_a);
    wr_valid = 1'b0;
  endtask

  task automatic wr_try(input int n);
    bit acc;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_a);
      wr_valid = 1'b1;
      wr_data  = gen(wcount);
      acc      = wr_ready;
      @(posedge clk_a);
      if (acc) wcount++;
    end
    @(negedge clk_a);
    wr_valid = 1'b0;
  endtask

  task automatic rd_words(input int n, input int gap);
    int got = 0;
    int it = 0;
    bit v;
    while (got < n) begin
      @(negedge clk_b);
      rd_ready = !(gap > 0 && (it % gap) == gap - 1);
      v = rd_valid;
      @(posedge clk_b);
      if (v && rd_ready) begin rcount++; got++; end
      it++;
    end
    @(negedge clk_b);
    rd_ready = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_a);
    repeat (n) @(negedge clk_b);
  endtask

  task automatic reload();
    @(negedge clk_b);
    rt_reload = 1'b1;
    @(posedge clk_b);
    rcount = rt_entry;
    @(negedge clk_b);
    rt_reload = 1'b0;
  endtask

  task automatic enter_rt();
    @(negedge clk_b);
    rt_mode  = 1'b1;
    in_rt    = 1'b1;
    rt_entry = rcount;
  endtask

  initial begin
    repeat (3) @(negedge clk_a);
    chk(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
    chk(wr_ready == 1'b1, "R1", "wr_ready in reset", wr_ready, 1);
    chk(rd_almost_empty == 1'b1, "R1", "almost_empty in reset", rd_almost_empty, 1);
    chk(wr_almost_full == 1'b0, "R1", "almost_full in reset", wr_almost_full, 0);
    rst_n = 1'b1;
    settle(3);
    mon_on = 1'b1;
    chk(rd_valid == 1'b0 && rd_almost_empty == 1'b1, "R1", "read side after reset", rd_valid, 0);
    chk(wr_ready == 1'b1 && wr_almost_full == 1'b0, "R1", "write side after reset", wr_ready, 1);

    // R5: thresholds on the read side
    wr_words(20, 0);
    settle(6);
    chk(rd_valid == 1'b1, "R2", "data present", rd_valid, 1);
    chk(rd_almost_empty == 1'b0, "R5", "fill 20", rd_almost_empty, 0);
    rd_words(11, 0);
    settle(4);
    chk(rd_almost_empty == 1'b0, "R5", "fill 9", rd_almost_empty, 0);
    rd_words(1, 0);
    settle(4);
    chk(rd_almost_empty == 1'b1, "R5", "fill 8", rd_almost_empty, 1);
    rd_words(8, 0);

    // R4: reads while empty are ignored
    @(negedge clk_b);
    rd_ready = 1'b1;
    repeat (10) @(negedge clk_b);
    rd_ready = 1'b0;
    chk(rcount == 20, "R4", "model count", rcount, 20);
    wr_words(1, 0);
    settle(6);
    chk(rd_data == gen(20), "R4", "word after empty reads", rd_data, gen(20));
    rd_words(1, 0);

    // R2: concurrent streaming with stalls on both sides
    fork
      wr_words(300, 3);
      rd_words(300, 4);
    join
    settle(8);
    chk(rd_valid == 1'b0, "R2", "drained after stream", rd_valid, 0);

    // R3 / R6: fill to the top
    wr_try(530);
    chk(wcount - rcount == DEPTH, "R3", "accepted count", wcount - rcount, DEPTH);
    settle(8);
    chk(wr_ready == 1'b0, "R3", "ready when full", wr_ready, 0);
    chk(wr_almost_full == 1'b1, "R6", "full", wr_almost_full, 1);
    rd_words(AF, 0);
    settle(10);
    chk(wr_almost_full == 1'b1, "R6", "fill 504", wr_almost_full, 1);
    chk(wr_ready == 1'b1, "R3", "ready at 504", wr_ready, 1);
    rd_words(1, 0);
    settle(10);
    chk(wr_almost_full == 1'b0, "R6", "fill 503", wr_almost_full, 0);
    wr_words(9, 0);
    settle(10);
    chk(wr_ready == 1'b0, "R3", "full again", wr_ready, 0);

    // R7 / R8 / R10: retransmit on a full buffer
    enter_rt();
    rd_words(40, 2);
    settle(10);
    chk(wr_ready == 1'b0, "R7", "no space freed in retransmit", wr_ready, 0);
    chk(wr_almost_full == 1'b1, "R7", "almost_full held", wr_almost_full, 1);
    reload();
    chk(rd_valid == 1'b1, "R8", "valid right after reload", rd_valid, 1);
    chk(rd_data == gen(rt_entry), "R8", "replay word", rd_data, gen(rt_entry));
    rd_words(10, 0);
    @(negedge clk_b);
    rt_mode = 1'b0;
    @(posedge clk_b);
    in_rt = 1'b0;
    @(negedge clk_a);
    chk(wr_ready == 1'b0, "R10", "space not yet seen", wr_ready, 0);
    settle(20);
    chk(wr_ready == 1'b1, "R10", "space after exit", wr_ready, 1);
    chk(wr_almost_full == 1'b0, "R7", "shadow caught up (fill 502)", wr_almost_full, 0);
    rd_words(wcount - rcount, 0);
    settle(6);
    chk(rd_valid == 1'b0, "R2", "drained after replay", rd_valid, 0);

    // R9: reload lifts the fill out of the almost-empty range
    wr_words(30, 0);
    settle(6);
    enter_rt();
    rd_words(25, 0);
    settle(4);
    chk(rd_almost_empty == 1'b1, "R9", "fill 5 before reload", rd_almost_empty, 1);
    reload();
    @(posedge clk_b);
    @(negedge clk_b);
    chk(rd_almost_empty == 1'b0, "R9", "fill 30 after reload", rd_almost_empty, 0);
    @(negedge clk_b);
    rt_mode = 1'b0;
    @(posedge clk_b);
    in_rt = 1'b0;
    rd_words(wcount - rcount, 3);
    settle(6);
    chk(rd_valid == 1'b0 && rd_almost_empty == 1'b1, "R5", "empty at end", rd_valid, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_a);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule